// File: doc/BRIEF.md
# Program Status Word with Register-Bank Addressing

This block is the status register of an 8-bit accumulator-based CPU core. It holds the carry, auxiliary carry and overflow flags, plus two general-purpose flags and a two-bit bank selector. It presents all eight bits as one byte on a special-function-register port at address D0h. The lowest bit is a parity flag that software cannot store. Hardware reloads it at the end of every instruction from the accumulator. The ALU updates the arithmetic flags through per-flag write enables. Software can write the whole byte, or set and clear single bits through the bit-addressable window D0h..D7h.

The two bank bits, together with a 3-bit working-register index from the decoder, form the internal RAM address of the selected working register. That address is produced combinationally, so a bank switch takes effect on the cycle after the write.

Top module: `psw_unit`

## Requirements
- R1: After reset all eight bits read 00h and the working-register address equals the index alone (bank 0).
- R2: A byte write to SFR address D0h loads bits 7 down to 1 on the next clock. Byte writes to any other address leave the register unchanged.
- R3: Bit 0 (parity) is never altered by a byte write or a bit write.
- R4: When `insn_done` is high, bit 0 takes the XOR of all eight accumulator bits at that edge: 1 when the accumulator holds an odd number of ones. Otherwise bit 0 holds.
- R5: A bit write at bit address D0h+n, where n is the position in the layout CY=7, AC=6, F0=5, RS1=4, RS0=3, OV=2, F1=1, P=0, sets or clears that bit only. Bit writes whose upper five address bits differ from 11010b have no effect.
- R6: The ALU enables load CY (bit 7), AC (bit 6) and OV (bit 2) independently. An enable that is low leaves its flag unchanged.
- R7: When an ALU enable and a software write (byte or bit) address the same flag in one cycle, the software value is stored.
- R8: The working-register address is {000b, RS1, RS0, idx[2:0]}, giving banks at 00h, 08h, 10h and 18h.
- R9: `sfr_rdata` shows the full register when `sfr_addr` is D0h and 00h otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR byte address for read and write |
| sfr_wr_en | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_rdata | output | 8 | Read data |
| bit_wr_en | input | 1 | Single-bit write strobe |
| bit_addr | input | 8 | Bit address |
| bit_val | input | 1 | Value for the addressed bit |
| alu_cy_we | input | 1 | Carry load enable |
| alu_cy | input | 1 | Carry from ALU |
| alu_ac_we | input | 1 | Auxiliary carry load enable |
| alu_ac | input | 1 | Auxiliary carry from ALU |
| alu_ov_we | input | 1 | Overflow load enable |
| alu_ov | input | 1 | Overflow from ALU |
| acc | input | 8 | Accumulator value |
| insn_done | input | 1 | End-of-instruction strobe |
| reg_idx | input | 3 | Working-register index |
| psw_q | output | 8 | Register contents |
| reg_addr | output | 8 | Internal RAM address of the working register |

## Verification
The bench writes FFh and then single-bit sets to bit 0. A design that let software store parity would show P=1 with an even accumulator. It presents ALU and software updates of CY together. A design with the wrong priority keeps the ALU carry. It drives bit addresses just outside the window (C8h-range and D8h) and byte writes to D1h. A loose decode would change flags there. It also sweeps all four banks with indexes 0 and 7, which exposes swapped or shifted bank bits in the RAM address.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W    = 8;
  localparam int CY_B     = 7;
  localparam int AC_B     = 6;
  localparam int F0_B     = 5;
  localparam int RS1_B    = 4;
  localparam int RS0_B    = 3;
  localparam int OV_B     = 2;
  localparam int F1_B     = 1;
  localparam int P_B      = 0;
  localparam logic [7:0] PSW_SFR_ADDR = 8'hD0;
endpackage

// File: rtl/psw_flag_reg.sv
module psw_flag_reg
  import psw_pkg::*;
#(
  parameter int W     = PSW_W,
  parameter int SEL_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_we,
  input  logic [W-1:0]     wdata,
  input  logic             bit_we,
  input  logic [SEL_W-1:0] bit_sel,
  input  logic             bit_val,
  input  logic             cy_we,
  input  logic             cy_d,
  input  logic             ac_we,
  input  logic             ac_d,
  input  logic             ov_we,
  input  logic             ov_d,
  output logic [W-1:1]     flags_q
);
  // one storage cell per software-visible bit; bit 0 lives elsewhere
  for (genvar i = 1; i < W; i++) begin : g_bit
    logic alu_we, alu_d, bw_hit, d_nxt, en;
    always_comb begin
      alu_we = 1'b0;
      alu_d  = 1'b0;
      if (i == CY_B) begin alu_we = cy_we; alu_d = cy_d; end
      if (i == AC_B) begin alu_we = ac_we; alu_d = ac_d; end
      if (i == OV_B) begin alu_we = ov_we; alu_d = ov_d; end
      bw_hit = bit_we && (bit_sel == SEL_W'(i));
      // software access outranks the ALU; a byte write outranks a bit write
      en    = byte_we || bw_hit || alu_we;
      d_nxt = byte_we ? wdata[i] : (bw_hit ? bit_val : alu_d);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flags_q[i] <= 1'b0;
      else if (en) flags_q[i] <= d_nxt;
    end
  end
endmodule

// File: rtl/psw_parity.sv
module psw_parity #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] acc,
  output logic         par_q
);
  logic par_d;
  always_comb par_d = ^acc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    par_q <= 1'b0;
    else if (load) par_q <= par_d;
  end
endmodule

// File: rtl/psw_bank_addr.sv
module psw_bank_addr #(
  parameter int BANK_W = 2,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 8
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD_W = ADDR_W - BANK_W - IDX_W;
  always_comb addr = {{PAD_W{1'b0}}, bank, idx};
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
#(
  parameter int         W       = PSW_W,
  parameter int         IDX_W   = 3,
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] SFR_ADR = PSW_SFR_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        sfr_addr,
  input  logic              sfr_wr_en,
  input  logic [W-1:0]      sfr_wdata,
  output logic [W-1:0]      sfr_rdata,
  input  logic              bit_wr_en,
  input  logic [7:0]        bit_addr,
  input  logic              bit_val,
  input  logic              alu_cy_we,
  input  logic              alu_cy,
  input  logic              alu_ac_we,
  input  logic              alu_ac,
  input  logic              alu_ov_we,
  input  logic              alu_ov,
  input  logic [W-1:0]      acc,
  input  logic              insn_done,
  input  logic [IDX_W-1:0]  reg_idx,
  output logic [W-1:0]      psw_q,
  output logic [ADDR_W-1:0] reg_addr
);
  localparam int SEL_W = $clog2(W);

  logic             byte_hit, bit_hit, rd_hit, par_q;
  logic [W-1:1]     flags_q;

  always_comb begin
    byte_hit = sfr_wr_en && (sfr_addr == SFR_ADR);
    bit_hit  = bit_wr_en && (bit_addr[7:SEL_W] == SFR_ADR[7:SEL_W]);
    rd_hit   = (sfr_addr == SFR_ADR);
  end

  psw_flag_reg #(.W(W), .SEL_W(SEL_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .byte_we(byte_hit), .wdata(sfr_wdata),
    .bit_we(bit_hit), .bit_sel(bit_addr[SEL_W-1:0]), .bit_val(bit_val),
    .cy_we(alu_cy_we), .cy_d(alu_cy),
    .ac_we(alu_ac_we), .ac_d(alu_ac),
    .ov_we(alu_ov_we), .ov_d(alu_ov),
    .flags_q(flags_q)
  );

  psw_parity #(.W(W)) u_par (
    .clk(clk), .rst_n(rst_n), .load(insn_done), .acc(acc), .par_q(par_q)
  );

  always_comb begin
    psw_q     = {flags_q, par_q};
    sfr_rdata = rd_hit ? psw_q : '0;
  end

  psw_bank_addr #(.BANK_W(2), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_bank (
    .bank(psw_q[RS1_B:RS0_B]), .idx(reg_idx), .addr(reg_addr)
  );
endmodule

// File: rtl/psw_unit_chk.sv
module psw_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] sfr_addr,
  input logic       sfr_wr_en,
  input logic [7:0] sfr_wdata,
  input logic       bit_wr_en,
  input logic [7:0] bit_addr,
  input logic       alu_cy_we,
  input logic       alu_cy,
  input logic       alu_ac_we,
  input logic       alu_ov_we,
  input logic [7:0] acc,
  input logic       insn_done,
  input logic [7:0] psw_q,
  input logic [7:0] reg_addr
);
  logic sw_byte, sw_bit, quiet;
  always_comb begin
    sw_byte = sfr_wr_en && sfr_addr == 8'hD0;
    sw_bit  = bit_wr_en && bit_addr[7:3] == 5'b11010;
    quiet   = !sw_byte && !sw_bit && !alu_cy_we && !alu_ac_we && !alu_ov_we;
  end

  p_parity_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_done |=> $stable(psw_q[0]));
  p_parity_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    insn_done |=> psw_q[0] == $past(^acc));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(psw_q[7:1]));
  p_alu_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_cy_we && !sw_byte && !sw_bit) |=> psw_q[7] == $past(alu_cy));
  p_byte_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_byte |=> psw_q[7:1] == $past(sfr_wdata[7:1]));
  p_bank_top_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr[7:5] == 3'b000);
endmodule

bind psw_unit psw_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr_en(sfr_wr_en),
  .sfr_wdata(sfr_wdata), .bit_wr_en(bit_wr_en), .bit_addr(bit_addr),
  .alu_cy_we(alu_cy_we), .alu_cy(alu_cy), .alu_ac_we(alu_ac_we),
  .alu_ov_we(alu_ov_we), .acc(acc), .insn_done(insn_done),
  .psw_q(psw_q), .reg_addr(reg_addr)
);

// File: tb/psw_unit_test.sv
module psw_unit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] sfr_addr, sfr_wdata, bit_addr, acc;
  logic       sfr_wr_en, bit_wr_en, bit_val;
  logic       alu_cy_we, alu_cy, alu_ac_we, alu_ac, alu_ov_we, alu_ov, insn_done;
  logic [2:0] reg_idx;
  logic [7:0] sfr_rdata, psw_q, reg_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_psw;

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_unit uut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr_en(sfr_wr_en),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .bit_wr_en(bit_wr_en),
    .bit_addr(bit_addr), .bit_val(bit_val), .alu_cy_we(alu_cy_we),
    .alu_cy(alu_cy), .alu_ac_we(alu_ac_we), .alu_ac(alu_ac),
    .alu_ov_we(alu_ov_we), .alu_ov(alu_ov), .acc(acc), .insn_done(insn_done),
    .reg_idx(reg_idx), .psw_q(psw_q), .reg_addr(reg_addr)
  );

  function automatic logic odd_ones(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) if (v[i]) c++;
    return (c % 2) == 1;
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    sfr_wr_en = 0; bit_wr_en = 0; alu_cy_we = 0; alu_ac_we = 0;
    alu_ov_we = 0; insn_done = 0;
  endtask

  // apply current inputs for one edge, then sample mid-cycle
  task automatic tick();
    @(posedge clk); #(CLK_PERIOD/4);
    idle();
  endtask

  task automatic t_reset();
    reg_idx = 3'd5;
    #1;
    check8("R1 reset psw", psw_q, 8'h00);
    check8("R1 reset reg_addr", reg_addr, 8'h05);
    sfr_addr = 8'hD0; #1;
    check8("R9 reset read", sfr_rdata, 8'h00);
  endtask

  task automatic t_byte_write();
    sfr_addr = 8'hD0; sfr_wdata = 8'hA5; sfr_wr_en = 1; tick();
    exp_psw = {8'hA5 & 8'hFE} | {7'b0, exp_psw[0]};
    check8("R2 byte write A5", psw_q, exp_psw);
    sfr_wdata = 8'hFF; sfr_wr_en = 1; tick();
    exp_psw = 8'hFE | {7'b0, exp_psw[0]};
    check8("R3 byte write cannot set P", psw_q, exp_psw);
    sfr_addr = 8'hD1; sfr_wdata = 8'h00; sfr_wr_en = 1; tick();
    check8("R2 write to D1h ignored", psw_q, exp_psw);
    sfr_addr = 8'hD0; #1;
    check8("R9 read at D0h", sfr_rdata, exp_psw);
    sfr_addr = 8'hE0; #1;
    check8("R9 read elsewhere is 0", sfr_rdata, 8'h00);
    sfr_addr = 8'hD0;
  endtask

  task automatic t_parity();
    acc = 8'b0000_0111; insn_done = 1; tick();
    exp_psw[0] = odd_ones(8'b0000_0111);
    check8("R4 odd acc sets P", psw_q, exp_psw);
    acc = 8'b1100_0000; tick();
    check8("R4 P holds without insn_done", psw_q, exp_psw);
    insn_done = 1; tick();
    exp_psw[0] = odd_ones(8'b1100_0000);
    check8("R4 even acc clears P", psw_q, exp_psw);
    bit_addr = 8'hD0; bit_val = 1; bit_wr_en = 1; tick();
    check8("R3 bit write to P ignored", psw_q, exp_psw);
  endtask

  task automatic t_bit_ops();
    sfr_wdata = 8'h00; sfr_wr_en = 1; tick();
    exp_psw = {7'b0, exp_psw[0]};
    for (int n = 1; n < 8; n++) begin
      bit_addr = 8'hD0 + 8'(n); bit_val = 1; bit_wr_en = 1; tick();
      exp_psw[n] = 1'b1;
      check8("R5 bit set", psw_q, exp_psw);
    end
    bit_addr = 8'hD5; bit_val = 0; bit_wr_en = 1; tick();
    exp_psw[5] = 1'b0;
    check8("R5 bit clear F0", psw_q, exp_psw);
    bit_addr = 8'hC9; bit_val = 0; bit_wr_en = 1; tick();
    check8("R5 bit addr C9h ignored", psw_q, exp_psw);
    bit_addr = 8'hD8; bit_val = 0; bit_wr_en = 1; tick();
    check8("R5 bit addr D8h ignored", psw_q, exp_psw);
  endtask

  task automatic t_alu();
    sfr_wdata = 8'h00; sfr_wr_en = 1; tick();
    exp_psw = {7'b0, exp_psw[0]};
    alu_cy_we = 1; alu_cy = 1; alu_ov_we = 1; alu_ov = 1; alu_ac = 1; tick();
    exp_psw[7] = 1; exp_psw[2] = 1;
    check8("R6 CY and OV load, AC held", psw_q, exp_psw);
    alu_ac_we = 1; alu_ac = 1; alu_cy = 0; tick();
    exp_psw[6] = 1;
    check8("R6 AC load only", psw_q, exp_psw);
  endtask

  task automatic t_conflict();
    sfr_wdata = 8'h00; sfr_wr_en = 1; alu_cy_we = 1; alu_cy = 1;
    alu_ov_we = 1; alu_ov = 1; tick();
    exp_psw = {7'b0, exp_psw[0]};
    check8("R7 byte write beats ALU", psw_q, exp_psw);
    bit_addr = 8'hD7; bit_val = 0; bit_wr_en = 1; alu_cy_we = 1; alu_cy = 1;
    alu_ac_we = 1; alu_ac = 1; tick();
    exp_psw[6] = 1;
    check8("R7 bit write beats ALU on CY", psw_q, exp_psw);
  endtask

  task automatic t_bank();
    for (int b = 0; b < 4; b++) begin
      sfr_wdata = 8'(b << 3); sfr_wr_en = 1; tick();
      exp_psw = 8'(b << 3) | {7'b0, exp_psw[0]};
      reg_idx = 3'd0; #1;
      check8("R8 bank base", reg_addr, 8'(8 * b));
      reg_idx = 3'd7; #1;
      check8("R8 bank top", reg_addr, 8'(8 * b + 7));
    end
  endtask

  initial begin
    idle();
    rst_n = 0; sfr_addr = 8'hD0; sfr_wdata = 0; bit_addr = 0; bit_val = 0;
    alu_cy = 0; alu_ac = 0; alu_ov = 0; acc = 0; reg_idx = 0;
    exp_psw = 8'h00;
    t_reset();
    @(negedge clk); rst_n = 1;
    t_byte_write();
    t_parity();
    t_bit_ops();
    t_alu();
    t_conflict();
    t_bank();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule